// File: doc/BRIEF.md
# Ownership-Flag Descriptor Ring Walker

This block walks a ring of receive descriptors held in a shared memory. A flag inside each descriptor says who may use that slot, so no head or tail register is exchanged with software. Software fills a descriptor with a buffer address and a buffer size, then sets the hardware-owned flag. The block reads the control word at its current ring position. If software still owns the slot, the block waits a programmable number of idle cycles and reads it again. If hardware owns the slot, the block fetches the buffer address and offers the buffer to the packet path.

When a finished packet length arrives, the block writes the control word back. The written word carries the length, clamped to the buffer size, and an overflow mark. The ownership flag is cleared and the end-of-ring flag is kept. The block then moves to the next descriptor. After a descriptor whose end-of-ring flag is set, it returns to the ring base, so the ring length lives in the ring itself.

Moving the payload is outside this block.

The packet-done input is a valid/ready stream:
- `pkt_ready` is high only while a hardware-owned buffer is on offer.
- A transfer happens on a clock edge where `pkt_valid` and `pkt_ready` are both high.
- The source holds `pkt_valid` and keeps `pkt_len` stable until that transfer.
- The offered buffer (`buf_addr`, `buf_size`) stays stable for as long as the packet path waits.

Top module: `dring_walker`

## Requirements
- R1: While `rst_n` is low, or after `enable` has been low for a clock edge, the block makes no memory access and raises neither `buf_valid` nor `pkt_ready`. When `enable` rises, the first control-word read is at `ring_base`.
- R2: A descriptor is 8 bytes. The control word is at offset 0 and the buffer address at offset 4. Memory data is little-endian: the byte at the lowest address sits on bits 7:0. In the control word, bit 31 set means hardware owns the slot and bit 30 marks the last slot. Bits 12:0 hold the buffer size, and bits 29:13 are ignored on read.
- R3: When the control word read shows hardware ownership, the next cycle reads the buffer address. `buf_valid` rises 3 cycles after the control read, with `buf_addr` and `buf_size` taken from the descriptor.
- R4: When the control word shows software ownership, the block makes no write and stays idle on the memory port. It reads the same control word again `poll_gap` + 3 cycles after the previous read.
- R5: `pkt_ready` is high only while `buf_valid` is high. While no transfer occurs, `buf_addr` and `buf_size` hold steady and no write is issued.
- R6: In the transfer cycle, the block writes the control word at the descriptor's offset 0. Bit 31 is 0 and bit 30 keeps the end-of-ring value. Bits 12:0 hold the stored length, and every other bit except the overflow bit is 0.
- R7: If `pkt_len` is greater than the buffer size, the written word has bit 16 set and bits 12:0 equal to the buffer size. Otherwise bit 16 is 0 and bits 12:0 equal `pkt_len`; a length equal to the size is not an overflow.
- R8: The cycle after a transfer, the block reads the next control word. It reads at the current address plus 8, or at `ring_base` if the finished descriptor had its end-of-ring flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the ring walk; low parks the position at the base |
| ring_base | input | ADDR_W | Byte address of the first descriptor (8-byte aligned) |
| poll_gap | input | POLL_W | Idle cycles inserted before re-reading a software-owned slot |
| mem_rd | output | 1 | Read request, data returned on the next cycle |
| mem_wr | output | 1 | Write request |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | 32 | Write data (little-endian word) |
| mem_rdata | input | 32 | Read data, valid the cycle after `mem_rd` |
| buf_valid | output | 1 | A hardware-owned buffer is on offer |
| buf_addr | output | 32 | Address of the offered buffer |
| buf_size | output | 13 | Size of the offered buffer in bytes |
| pkt_valid | input | 1 | Packet-done length is valid |
| pkt_ready | output | 1 | Block accepts a packet-done length |
| pkt_len | input | 13 | Received length in bytes |

## Verification
The bench timestamps every control-word read on the memory port. Each offered buffer is checked to appear exactly 3 cycles after its read. Each re-read of a software-owned slot is checked to come exactly `poll_gap` + 3 cycles after the previous one. A write-back is due combinationally in the transfer cycle, so the monitor pops its scoreboard entry at the falling edge of that cycle. The next control read is checked at the falling edge of the following cycle, and inputs change only just after rising edges, so each check lands in the cycle its requirement names.

// File: rtl/dring_pkg.sv
package dring_pkg;
  localparam int WORD_W      = 32;
  localparam int SIZE_W      = 13;
  localparam int OWN_BIT     = 31;
  localparam int LAST_BIT    = 30;
  localparam int OVF_BIT     = 16;
  localparam int DESC_BYTES  = 8;
  localparam int BUF_OFS     = 4;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_RD_CTL,
    ST_CAP_CTL,
    ST_CAP_BUF,
    ST_READY,
    ST_WAIT
  } walk_state_t;

  typedef struct packed {
    logic              own;
    logic              last;
    logic [SIZE_W-1:0] size;
  } ctl_fields_t;

  function automatic ctl_fields_t decode_ctl(input logic [WORD_W-1:0] w);
    ctl_fields_t f;
    f.own  = w[OWN_BIT];
    f.last = w[LAST_BIT];
    f.size = w[SIZE_W-1:0];
    return f;
  endfunction
endpackage

// File: rtl/dring_poll_timer.sv
module dring_poll_timer #(
  parameter int POLL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              dec,
  input  logic [POLL_W-1:0] gap,
  output logic              expired
);
  logic [POLL_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (load)                  cnt_q <= gap;
    else if (dec && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R4: a non-zero gap always yields at least one idle cycle
  p_gap_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && gap != '0) |=> !expired);
endmodule

// File: rtl/dring_ring_ptr.sv
module dring_ring_ptr #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reload,
  input  logic              step,
  input  logic              wrap,
  input  logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] cur
);
  import dring_pkg::*;
  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(DESC_BYTES);

  logic [ADDR_W-1:0] base_al;
  assign base_al = {base[ADDR_W-1:3], 3'b000};

  always_ff @(posedge clk) begin
    if (!rst_n)                 cur <= base_al;
    else if (reload)            cur <= base_al;
    else if (step && wrap)      cur <= base_al;
    else if (step)              cur <= cur + STRIDE;
  end

  // R8: a plain step moves exactly one descriptor forward
  p_stride_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wrap && !reload) |=> cur == $past(cur) + STRIDE);
endmodule

// File: rtl/dring_wb_format.sv
module dring_wb_format (
  input  logic [dring_pkg::SIZE_W-1:0] len,
  input  logic [dring_pkg::SIZE_W-1:0] size,
  input  logic                         last,
  output logic [dring_pkg::WORD_W-1:0] word
);
  import dring_pkg::*;
  logic              ovf;
  logic [SIZE_W-1:0] stored;

  always_comb begin
    ovf    = (len > size);
    stored = ovf ? size : len;
    word   = '0;
    word[OWN_BIT]      = 1'b0;
    word[LAST_BIT]     = last;
    word[OVF_BIT]      = ovf;
    word[SIZE_W-1:0]   = stored;
  end
endmodule

// File: rtl/dring_walker.sv
module dring_walker #(
  parameter int ADDR_W = 16,
  parameter int POLL_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          enable,
  input  logic [ADDR_W-1:0]             ring_base,
  input  logic [POLL_W-1:0]             poll_gap,
  output logic                          mem_rd,
  output logic                          mem_wr,
  output logic [ADDR_W-1:0]             mem_addr,
  output logic [31:0]                   mem_wdata,
  input  logic [31:0]                   mem_rdata,
  output logic                          buf_valid,
  output logic [31:0]                   buf_addr,
  output logic [dring_pkg::SIZE_W-1:0]  buf_size,
  input  logic                          pkt_valid,
  output logic                          pkt_ready,
  input  logic [dring_pkg::SIZE_W-1:0]  pkt_len
);
  import dring_pkg::*;
  localparam logic [ADDR_W-1:0] ADDR_OFS = ADDR_W'(BUF_OFS);

  walk_state_t       state_q, state_d;
  ctl_fields_t       ctl_now;
  logic              last_q;
  logic [SIZE_W-1:0] size_q;
  logic [31:0]       bufa_q;
  logic [ADDR_W-1:0] cur;
  logic              tmr_load, tmr_dec, tmr_expired;
  logic              xfer;
  logic [31:0]       wb_word;

  assign ctl_now = decode_ctl(mem_rdata);
  assign xfer    = (state_q == ST_READY) && pkt_valid;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_dec  = 1'b0;
    unique case (state_q)
      ST_OFF:     state_d = ST_RD_CTL;
      ST_RD_CTL:  state_d = ST_CAP_CTL;
      ST_CAP_CTL: begin
        if (ctl_now.own) state_d = ST_CAP_BUF;
        else begin
          state_d  = ST_WAIT;
          tmr_load = 1'b1;
        end
      end
      ST_CAP_BUF: state_d = ST_READY;
      ST_READY:   if (pkt_valid) state_d = ST_RD_CTL;
      ST_WAIT: begin
        tmr_dec = 1'b1;
        if (tmr_expired) state_d = ST_RD_CTL;
      end
      default:    state_d = ST_OFF;
    endcase
    if (!enable) state_d = ST_OFF;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      last_q  <= 1'b0;
      size_q  <= '0;
      bufa_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_CAP_CTL && ctl_now.own) begin
        last_q <= ctl_now.last;
        size_q <= ctl_now.size;
      end
      if (state_q == ST_CAP_BUF) bufa_q <= mem_rdata;
    end
  end

  dring_poll_timer #(.POLL_W(POLL_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .dec     (tmr_dec),
    .gap     (poll_gap),
    .expired (tmr_expired)
  );

  dring_ring_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .reload (state_q == ST_OFF),
    .step   (xfer),
    .wrap   (last_q),
    .base   (ring_base),
    .cur    (cur)
  );

  dring_wb_format u_fmt (
    .len  (pkt_len),
    .size (size_q),
    .last (last_q),
    .word (wb_word)
  );

  always_comb begin
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_addr  = cur;
    mem_wdata = wb_word;
    case (state_q)
      ST_RD_CTL:  mem_rd = 1'b1;
      ST_CAP_CTL: begin
        mem_rd   = ctl_now.own;
        mem_addr = cur + ADDR_OFS;
      end
      ST_READY:   mem_wr = pkt_valid;
      default: ;
    endcase
  end

  assign buf_valid = (state_q == ST_READY);
  assign pkt_ready = buf_valid;
  assign buf_addr  = bufa_q;
  assign buf_size  = size_q;

  // R1: dropping enable silences the memory port and the offer
  p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!mem_rd && !mem_wr && !buf_valid));
  // R2: every access is word aligned
  p_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> mem_addr[1:0] == 2'b00);
  // R4: waiting leaves the memory port idle
  p_wait_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) |-> (!mem_rd && !mem_wr));
  // R5: an unaccepted offer holds steady
  p_offer_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_valid && !pkt_valid && enable) |=>
      (buf_valid && $stable(buf_addr) && $stable(buf_size)));
  // R6: write-back always hands the slot back to software
  p_own_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> !mem_wdata[OWN_BIT]);
  // R7: stored length never exceeds the buffer
  p_len_clamp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> mem_wdata[SIZE_W-1:0] <= buf_size);
  // R7: without the overflow mark the length is passed through
  p_len_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !mem_wdata[OVF_BIT]) |-> mem_wdata[SIZE_W-1:0] == pkt_len);
  // R8: a transfer is followed at once by a control read
  p_refetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_ready && enable) |=> (mem_rd && !mem_wr));
endmodule

// File: tb/dring_walker_tb_top.sv
module dring_walker_tb_top;
  localparam int AW = 16;
  localparam int PW = 8;
  localparam logic [AW-1:0] BASE = 16'h0100;
  localparam int GAP = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [AW-1:0] ring_base = BASE;
  logic [PW-1:0] poll_gap = PW'(GAP);
  logic mem_rd, mem_wr;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic buf_valid, pkt_ready;
  logic [31:0] buf_addr;
  logic [12:0] buf_size;
  logic pkt_valid = 1'b0;
  logic [12:0] pkt_len = '0;

  always #10 clk = ~clk;

  dring_walker #(.ADDR_W(AW), .POLL_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ring_base(ring_base),
    .poll_gap(poll_gap), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .buf_valid(buf_valid), .buf_addr(buf_addr), .buf_size(buf_size),
    .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_len(pkt_len)
  );

  logic [31:0] mem [0:255];
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[9:2]];
    if (mem_wr) mem[mem_addr[9:2]] <= mem_wdata;
  end

  int n_chk = 0, n_fail = 0, cyc = 0;
  int last_ctl_cyc = 0, prev_ctl_cyc = 0, ctl_cnt = 0, wr_cnt = 0;
  logic [AW-1:0] last_ctl_addr = '0;
  logic [AW-1:0] exp_wa[$];
  logic [31:0]   exp_wd[$];
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each write, logs control reads
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_wr) begin
        wr_cnt++;
        if (exp_wd.size() == 0)
          check(0, "R5", "unexpected write", mem_wdata, 32'h0);
        else begin
          logic [AW-1:0] a;
          logic [31:0] d;
          a = exp_wa.pop_front();
          d = exp_wd.pop_front();
          check(mem_addr == a, "R6", "write-back address", 32'(mem_addr), 32'(a));
          check(mem_wdata == d, "R7", "write-back word", mem_wdata, d);
        end
      end
      if (mem_rd && !mem_addr[2]) begin
        prev_ctl_cyc  = last_ctl_cyc;
        last_ctl_cyc  = cyc;
        last_ctl_addr = mem_addr;
        ctl_cnt++;
      end
    end
  end

  function automatic logic [31:0] wb_exp(input int len, input int size, input bit last);
    bit ovf;
    int st;
    ovf = len > size;
    st  = ovf ? size : len;
    return {1'b0, last, 13'b0, ovf, 3'b0, 13'(st)};
  endfunction

  task automatic send(input int len, input logic [AW-1:0] at, input int size,
                      input bit last, input logic [31:0] baddr, input int hold,
                      input logic [AW-1:0] nxt);
    do @(negedge clk); while (!buf_valid);
    check(cyc - last_ctl_cyc == 3, "R3", "offer latency", 32'(cyc - last_ctl_cyc), 32'd3);
    check(buf_addr == baddr, "R3", "buffer address", buf_addr, baddr);
    check(buf_size == 13'(size), "R2", "buffer size field", 32'(buf_size), 32'(size));
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check(pkt_ready && buf_valid && buf_addr == baddr, "R5", "offer held",
            {pkt_ready, buf_valid, buf_addr[29:0]}, {2'b11, baddr[29:0]});
    end
    exp_wa.push_back(at);
    exp_wd.push_back(wb_exp(len, size, last));
    @(posedge clk); #1;
    pkt_valid = 1'b1;
    pkt_len   = 13'(len);
    @(posedge clk); #1;
    pkt_valid = 1'b0;
    @(negedge clk);
    check(mem_rd && mem_addr == nxt, "R8", "next control read",
          {mem_rd, 15'b0, mem_addr}, {1'b1, 15'b0, nxt});
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    // ring of 4; bits 29:13 carry junk that must be ignored
    mem[64] = 32'h80AA_0000 | 32'd100;  mem[65] = 32'h0000_1000;
    mem[66] = 32'h8000_0000 | 32'd200;  mem[67] = 32'h0000_2000;
    mem[68] = 32'h8154_0000 | 32'd64;   mem[69] = 32'h0000_3000;
    mem[70] = 32'hC000_0000 | 32'd1500; mem[71] = 32'h0000_4000;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!mem_rd && !mem_wr && !buf_valid && !pkt_ready, "R1", "reset quiet",
          {mem_rd, mem_wr, buf_valid, pkt_ready}, 32'h0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!mem_rd && !buf_valid, "R1", "disabled quiet", {mem_rd, buf_valid}, 32'h0);
    @(posedge clk); #1 enable = 1'b1;

    send(50,   16'h0100, 100,  0, 32'h1000, 0, 16'h0108);
    send(300,  16'h0108, 200,  0, 32'h2000, 4, 16'h0110);  // overflow, back-pressure
    send(64,   16'h0110, 64,   0, 32'h3000, 0, 16'h0118);  // exact fit
    send(1500, 16'h0118, 1500, 1, 32'h4000, 0, 16'h0100);  // end of ring wraps

    // slot 0 now belongs to software: expect polling
    begin
      int c0, w0;
      c0 = ctl_cnt;
      w0 = wr_cnt;
      while (ctl_cnt < c0 + 2) @(negedge clk);
      check(last_ctl_cyc - prev_ctl_cyc == GAP + 3, "R4", "poll interval",
            32'(last_ctl_cyc - prev_ctl_cyc), 32'(GAP + 3));
      check(last_ctl_addr == BASE, "R4", "poll address", 32'(last_ctl_addr), 32'(BASE));
      check(wr_cnt == w0, "R4", "no write while stalled", 32'(wr_cnt), 32'(w0));
      @(negedge clk);
      check(!buf_valid && !pkt_ready, "R5", "no offer while stalled",
            {buf_valid, pkt_ready}, 32'h0);
    end

    // hand slot 0 back with a small buffer
    @(posedge clk); #1;
    mem[64] = 32'h8000_0000 | 32'd80;
    mem[65] = 32'h0000_5000;
    send(90, 16'h0100, 80, 0, 32'h5000, 0, 16'h0108);

    // disable, then re-enable: restart at base
    repeat (4) @(negedge clk);
    @(posedge clk); #1 enable = 1'b0;
    repeat (2) @(negedge clk);
    check(!mem_rd && !mem_wr && !buf_valid, "R1", "disabled quiet",
          {mem_rd, mem_wr, buf_valid}, 32'h0);
    @(posedge clk); #1 enable = 1'b1;
    begin
      int c1;
      c1 = ctl_cnt;
      while (ctl_cnt == c1) @(negedge clk);
      check(last_ctl_addr == BASE, "R1", "restart at base", 32'(last_ctl_addr), 32'(BASE));
    end
    check(exp_wd.size() == 0, "R6", "scoreboard drained", 32'(exp_wd.size()), 32'h0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule